// File: doc/BRIEF.md
# Paged ROM Table-Read Unit

This unit lets a small 8-bit processor read constants stored in its 4096-word program ROM. Software loads an 8-bit table pointer through the register file and then issues a table-read command. The command selects one of two 256-word pages. The first is the page the program counter is in now. The second is the highest page of the ROM.

The unit builds the 12-bit ROM address from the page bits and the pointer. It reads the 15-bit word over a synchronous ROM port. The low byte is returned as a one-cycle write strobe to a data-memory address that the command names. The remaining seven bits are kept in a read-only high-byte register, and the top bit of that register reads as zero.

Each table read takes two clock cycles. In the issue cycle the ROM address and enable are presented. In the second cycle the unit is busy and the ROM data comes back. The results appear on the clock edge that ends the second cycle.

Top module: `tblrd_unit`

## Requirements
- R1: After synchronous reset, the pointer register (address 0x07) and the high-byte register (address 0x08) both read 0x00, and `busy`, `done` and `dm_we` are low.
- R2: A register write to address 0x07 loads `reg_wdata` into the pointer. `reg_rdata` shows the pointer combinationally whenever `reg_addr` is 0x07.
- R3: Address 0x08 is read-only. A write to it leaves the high-byte value unchanged. Any address other than 0x07 or 0x08 reads 0x00.
- R4: With `cmd_last` = 0, an accepted command drives `rom_en` high in the same cycle, with `rom_addr` = {`pc_page`[3:0], pointer[7:0]}.
- R5: With `cmd_last` = 1, an accepted command drives `rom_addr` = {4'b1111, pointer[7:0]}, whatever `pc_page` holds.
- R6: In the cycle after acceptance, `busy` is high and `done` is low. In the following cycle `done` and `dm_we` are high for exactly one cycle and `busy` is low.
- R7: During the `dm_we` strobe, `dm_wdata` equals ROM word bits [7:0] and `dm_addr` equals the `cmd_dst` value captured when the command was accepted.
- R8: From the `done` cycle onward, the high-byte register reads {1'b0, ROM word bits [14:8]}.
- R9: A new command may be issued in the `done` cycle, and it is accepted there.
- R10: While `busy` is high, `cmd_valid` is ignored: `rom_en` stays low and no extra result is produced.
- R11: A pointer write in the same cycle as a command leaves that command's ROM address built from the previous pointer value. The pointer then holds the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register-file write enable |
| reg_addr | input | 8 | Register-file address |
| reg_wdata | input | 8 | Register-file write data |
| reg_rdata | output | 8 | Register-file read data (combinational) |
| cmd_valid | input | 1 | Table-read command request |
| cmd_last | input | 1 | 1 = highest page, 0 = current page |
| cmd_dst | input | 8 | Data-memory destination of the low byte |
| pc_page | input | 4 | Program counter bits 11..8 |
| rom_en | output | 1 | ROM read enable |
| rom_addr | output | 12 | ROM word address |
| rom_data | input | 15 | ROM word, valid the cycle after `rom_en` |
| busy | output | 1 | High in the second cycle of a read |
| done | output | 1 | One-cycle completion pulse |
| dm_we | output | 1 | Data-memory write strobe |
| dm_addr | output | 8 | Data-memory write address |
| dm_wdata | output | 8 | Data-memory write data (ROM low byte) |

## Verification
The embedded assertions assume that `rom_data` comes from a ROM that registers its word on the edge where `rom_en` is high, so the word is present in the busy cycle. They also assume that no register write is made in a reset cycle. The stimulus drives every input half a cycle away from the active edge and attaches a registered ROM model whose words are computed from the address. The stimulus raises `cmd_valid` during `busy` only in the single case that checks the command is ignored.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;
  typedef enum logic {ST_IDLE, ST_FETCH} seq_st_e;
endpackage

// File: rtl/tblrd_addr.sv
module tblrd_addr #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic [AW-DW-1:0] pc_page,
  input  logic             last,
  input  logic [DW-1:0]    ptr,
  output logic [AW-1:0]    addr
);
  localparam int PW = AW - DW;
  logic [PW-1:0] page;

  // last page is the all-ones page
  assign page = last ? {PW{1'b1}} : pc_page;
  assign addr = {page, ptr};
endmodule

// File: rtl/tblrd_regs.sv
module tblrd_regs #(
  parameter int         DW     = 8,
  parameter int         HW     = 7,
  parameter int         RAW    = 8,
  parameter logic [7:0] P_ADDR = 8'h07,
  parameter logic [7:0] H_ADDR = 8'h08
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [RAW-1:0] addr,
  input  logic [DW-1:0]  wdata,
  input  logic           h_ld,
  input  logic [HW-1:0]  h_din,
  output logic [DW-1:0]  ptr,
  output logic [DW-1:0]  hbyte,
  output logic [DW-1:0]  rdata
);
  localparam int PADW = DW - HW;
  logic [DW-1:0] ptr_q, hb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (we && addr == RAW'(P_ADDR)) begin
      ptr_q <= wdata;
    end
  end

  generate
    if (PADW > 0) begin : g_fill
      always_ff @(posedge clk) begin
        if (rst)       hb_q <= '0;
        else if (h_ld) hb_q <= {{PADW{1'b0}}, h_din};
      end
    end else begin : g_full
      always_ff @(posedge clk) begin
        if (rst)       hb_q <= '0;
        else if (h_ld) hb_q <= h_din[DW-1:0];
      end
    end
  endgenerate

  always_comb begin
    if (addr == RAW'(P_ADDR))      rdata = ptr_q;
    else if (addr == RAW'(H_ADDR)) rdata = hb_q;
    else                           rdata = '0;
  end

  assign ptr   = ptr_q;
  assign hbyte = hb_q;

  // R2 pointer write lands
  a_r2_ptr_write: assert property (@(posedge clk) disable iff (rst)
    (we && addr == RAW'(P_ADDR)) |=> (ptr_q == $past(wdata)));
  // R3 high byte ignores writes
  a_r3_hbyte_ro: assert property (@(posedge clk) disable iff (rst)
    (we && addr == RAW'(H_ADDR) && !h_ld) |=> $stable(hb_q));
endmodule

// File: rtl/tblrd_seq.sv
module tblrd_seq
  import tblrd_pkg::*;
#(
  parameter int DW   = 8,
  parameter int DSTW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [DSTW-1:0] cmd_dst,
  input  logic [DW-1:0]   rom_lo,
  output logic            issue,
  output logic            busy,
  output logic            done,
  output logic            dm_we,
  output logic [DSTW-1:0] dm_addr,
  output logic [DW-1:0]   dm_wdata
);
  seq_st_e         st_q;
  logic [DSTW-1:0] dst_q;

  assign issue = cmd_valid && (st_q == ST_IDLE);
  assign busy  = (st_q == ST_FETCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      dst_q    <= '0;
      done     <= 1'b0;
      dm_we    <= 1'b0;
      dm_addr  <= '0;
      dm_wdata <= '0;
    end else begin
      done  <= 1'b0;
      dm_we <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            st_q  <= ST_FETCH;
            dst_q <= cmd_dst;
          end
        end
        default: begin
          st_q     <= ST_IDLE;
          done     <= 1'b1;
          dm_we    <= 1'b1;
          dm_addr  <= dst_q;
          dm_wdata <= rom_lo;
        end
      endcase
    end
  end

  // R6 busy lasts one cycle and is followed by done
  a_r6_busy_single: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy && done));
  // R6 done is a single-cycle pulse preceded by busy
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));
  // R7 destination captured at acceptance
  a_r7_dst_kept: assert property (@(posedge clk) disable iff (rst)
    dm_we |-> (dm_addr == $past(cmd_dst, 2)));
endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit #(
  parameter int         AW        = 12,
  parameter int         DW        = 8,
  parameter int         HW        = 7,
  parameter int         RAW       = 8,
  parameter int         DSTW      = 8,
  parameter logic [7:0] TBLP_ADDR = 8'h07,
  parameter logic [7:0] TBLH_ADDR = 8'h08
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [RAW-1:0]   reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             cmd_valid,
  input  logic             cmd_last,
  input  logic [DSTW-1:0]  cmd_dst,
  input  logic [AW-DW-1:0] pc_page,
  output logic             rom_en,
  output logic [AW-1:0]    rom_addr,
  input  logic [DW+HW-1:0] rom_data,
  output logic             busy,
  output logic             done,
  output logic             dm_we,
  output logic [DSTW-1:0]  dm_addr,
  output logic [DW-1:0]    dm_wdata
);
  localparam int RW = DW + HW;
  localparam int PW = AW - DW;

  logic [DW-1:0] ptr, hbyte;
  logic          issue;

  tblrd_seq #(.DW(DW), .DSTW(DSTW)) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_dst(cmd_dst),
    .rom_lo(rom_data[DW-1:0]), .issue(issue), .busy(busy), .done(done),
    .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata)
  );

  tblrd_addr #(.AW(AW), .DW(DW)) u_addr (
    .pc_page(pc_page), .last(cmd_last), .ptr(ptr), .addr(rom_addr)
  );

  tblrd_regs #(.DW(DW), .HW(HW), .RAW(RAW), .P_ADDR(TBLP_ADDR), .H_ADDR(TBLH_ADDR)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .h_ld(busy), .h_din(rom_data[RW-1:DW]), .ptr(ptr), .hbyte(hbyte),
    .rdata(reg_rdata)
  );

  assign rom_en = issue;

  // R4 current page taken from the program counter
  a_r4_cur_page: assert property (@(posedge clk) disable iff (rst)
    (rom_en && !cmd_last) |-> (rom_addr[AW-1:DW] == pc_page));
  // R5 last page forced to all ones
  a_r5_last_page: assert property (@(posedge clk) disable iff (rst)
    (rom_en && cmd_last) |-> (rom_addr[AW-1:DW] == {PW{1'b1}}));
  // R10 no ROM access while busy
  a_r10_hold_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !rom_en);
  // R7 low byte is the word fetched in the busy cycle
  a_r7_low_byte: assert property (@(posedge clk) disable iff (rst)
    dm_we |-> (dm_wdata == $past(rom_data[DW-1:0])));
  // R8 high byte zero-filled with upper ROM bits
  a_r8_hbyte_fill: assert property (@(posedge clk) disable iff (rst)
    done |-> (hbyte == DW'($past(rom_data[RW-1:DW]))));
endmodule

// File: tb/tblrd_unit_tb.sv
module tblrd_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h08;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        cmd_valid = 1'b0;
  logic        cmd_last = 1'b0;
  logic [7:0]  cmd_dst = '0;
  logic [3:0]  pc_page = '0;
  logic        rom_en;
  logic [11:0] rom_addr;
  logic [14:0] rom_data = '0;
  logic        busy, done, dm_we;
  logic [7:0]  dm_addr, dm_wdata;

  int total = 0;
  int bad = 0;
  logic [7:0] last_hi = 8'h00;
  logic [23:0] exp_q[$];

  always #2.5 clk = ~clk;

  tblrd_unit u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
    .cmd_last(cmd_last), .cmd_dst(cmd_dst), .pc_page(pc_page),
    .rom_en(rom_en), .rom_addr(rom_addr), .rom_data(rom_data),
    .busy(busy), .done(done), .dm_we(dm_we), .dm_addr(dm_addr),
    .dm_wdata(dm_wdata)
  );

  function automatic logic [14:0] rom_fn(input logic [11:0] a);
    return {a[3:0], a[11:1]} ^ 15'h5A5A;
  endfunction

  always_ff @(posedge clk) if (rom_en) rom_data <= rom_fn(rom_addr);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && dm_we) begin
      logic [23:0] e;
      if (exp_q.size() == 0) begin
        check(0, "R10 unexpected result", dm_addr, 0);
      end else begin
        e = exp_q.pop_front();
        check(dm_addr == e[23:16], "R7 dm_addr", dm_addr, e[23:16]);
        check(dm_wdata == e[15:8], "R7 dm_wdata", dm_wdata, e[15:8]);
        check(reg_rdata == e[7:0], "R8 high byte", reg_rdata, e[7:0]);
        check(done && !busy, "R6 done cycle", {done, busy}, 2'b10);
        last_hi = e[7:0];
      end
    end
  end

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 8'h08;
  endtask

  task automatic reg_read(input logic [7:0] a, input logic [7:0] e, input string tag);
    reg_addr = a;
    #1;
    check(reg_rdata == e, tag, reg_rdata, e);
    reg_addr = 8'h08;
  endtask

  // issue at current negedge, returns at the busy-cycle negedge
  task automatic issue(input bit last, input logic [3:0] pg, input logic [7:0] ptr,
                       input logic [7:0] dst);
    logic [11:0] ea;
    logic [14:0] w;
    ea = {last ? 4'hF : pg, ptr};
    w  = rom_fn(ea);
    cmd_valid = 1'b1; cmd_last = last; pc_page = pg; cmd_dst = dst;
    #1;
    check(rom_en && rom_addr == ea, last ? "R5 last page addr" : "R4 current page addr",
          rom_addr, ea);
    exp_q.push_back({dst, w[7:0], 1'b0, w[14:8]});
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy && !done, "R6 busy cycle", {busy, done}, 2'b10);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(!busy && !done && !dm_we, "R1 control outputs", {busy, done, dm_we}, 0);
    reg_read(8'h07, 8'h00, "R1 pointer reset");
    reg_read(8'h08, 8'h00, "R1 high byte reset");
    @(negedge clk);

    // R2 pointer read/write
    reg_write(8'h07, 8'h3C);
    reg_read(8'h07, 8'h3C, "R2 pointer readback");

    // R4 current page reads
    issue(1'b0, 4'h2, 8'h3C, 8'h40); @(negedge clk); @(negedge clk);
    reg_write(8'h07, 8'hFF);
    issue(1'b0, 4'hF, 8'hFF, 8'h41); @(negedge clk); @(negedge clk);
    reg_write(8'h07, 8'h00);
    issue(1'b0, 4'h0, 8'h00, 8'h42); @(negedge clk); @(negedge clk);

    // R5 last page ignores pc_page
    reg_write(8'h07, 8'h81);
    issue(1'b1, 4'h3, 8'h81, 8'h50); @(negedge clk); @(negedge clk);
    issue(1'b1, 4'h0, 8'h81, 8'h51); @(negedge clk); @(negedge clk);

    // R3 write to high byte ignored, other addresses read zero
    reg_write(8'h08, 8'hAA);
    reg_read(8'h08, last_hi, "R3 high byte unchanged");
    reg_read(8'h09, 8'h00, "R3 unmapped reads zero");
    reg_read(8'h06, 8'h00, "R3 unmapped reads zero");

    // R9 back-to-back: issue in the done cycle
    reg_write(8'h07, 8'h5E);
    issue(1'b0, 4'h7, 8'h5E, 8'h60); @(negedge clk);
    issue(1'b1, 4'h7, 8'h5E, 8'h61); @(negedge clk);
    check(done, "R9 second done", done, 1);
    @(negedge clk);

    // R10 command during busy ignored
    issue(1'b0, 4'h9, 8'h5E, 8'h70);
    cmd_valid = 1'b1; cmd_dst = 8'h77;
    #1;
    check(!rom_en, "R10 no rom_en while busy", rom_en, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    check(!busy && !done, "R10 no extra op", {busy, done}, 0);

    // R11 pointer write in the issue cycle
    reg_write(8'h07, 8'h10);
    reg_we = 1'b1; reg_addr = 8'h07; reg_wdata = 8'h99;
    issue(1'b0, 4'h4, 8'h10, 8'h80);
    reg_we = 1'b0; reg_addr = 8'h08;
    @(negedge clk); @(negedge clk);
    reg_read(8'h07, 8'h99, "R11 pointer holds new value");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R6 all results seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule